// File: doc/BRIEF.md
# Datapath Function Unit

This block is the purely combinational execution stage of an n-bit datapath. It takes two operands, `opnd_a` and `opnd_b`, and a 4-bit operation code, and returns a result together with four status flags: overflow, carry, negative and zero.

The single operation code selects every part of the unit. The code is decoded into three controls: a select for the arithmetic/logic unit, a select for a one-position shifter that works on `opnd_b`, and the select for the output multiplexer. The arithmetic half of the code space is an adder. The adder's second operand is zero, B, the inverse of B, or all ones, and the lowest code bit is the carry-in. Increment, subtract and decrement all come out of that one adder.

The result drives the zero and negative flags for every code. Carry and overflow come from the adder, and are held low for the logic codes and for the shift and pass codes.

Top module: `fn_unit`

## Requirements
- R1: The codes 0000 to 0111 give, in order: A, A+1, A+B, A+B+1, A+~B, A+~B+1, A-1 and A. All results are taken modulo 2^WIDTH.
- R2: For codes 0000 to 0111, `cout` is the carry out of the WIDTH-bit sum of A, the selected second operand and the carry-in. The carry-in is code bit 0. For code 0111 this means `cout` is 1.
- R3: For codes 0000 to 0111, `ovf` is 1 exactly when A and the selected second operand have the same top bit and the sum's top bit differs from it.
- R4: The logic codes give: 1000 gives A AND B, 1001 gives A OR B, 1010 gives A XOR B, and 1011 gives NOT A.
- R5: Code 1100 outputs B unchanged.
- R6: Code 1101 shifts B right one place and puts a 0 into the top bit.
- R7: Code 1110 shifts B left one place and puts a 0 into bit 0.
- R8: For codes 1000 to 1111, `cout` and `ovf` are 0.
- R9: Code 1111 gives a result of 0.
- R10: `zero` is 1 exactly when the result is 0, for every code.
- R11: `neg` equals the top bit of the result, for every code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand; the shifter's only input |
| fsel | input | 4 | Operation code |
| result | output | WIDTH | Selected result |
| ovf | output | 1 | Signed overflow of the adder |
| cout | output | 1 | Carry out of the adder |
| neg | output | 1 | Top bit of the result |
| zero | output | 1 | Result is all zeros |

## Verification
Every code is driven with a set of fixed corner operands and with random pairs.

The corner operands are zero, all ones, the most negative and most positive values, and alternating bit patterns. They separate the cases where carry and overflow must be set from the cases where they must stay clear. They also show whether a shift fills with zero, and they expose swapped adder operand choices, such as increment versus decrement.

Random pairs show that the logic and shift codes act on the correct operand.

Zero and negative are compared on every vector. This covers the unused code, whose result of zero must raise the zero flag.

// File: rtl/fn_unit_pkg.sv
package fn_unit_pkg;
  // Decoded controls produced from the 4-bit operation code.
  typedef struct packed {
    logic       use_shift;  // output mux: 1 picks the shifter path
    logic [1:0] sh_sel;     // shifter: 0 pass, 1 right, 2 left, 3 zero
    logic [3:0] alu_sel;    // ALU: bit 3 = logic group, [2:1] operand, [0] carry-in
  } fn_ctl_t;
endpackage

// File: rtl/fn_decode.sv
module fn_decode
  import fn_unit_pkg::*;
(
  input  logic [3:0] fsel,
  output fn_ctl_t    ctl
);
  always_comb begin
    ctl.use_shift = fsel[3] & fsel[2];
    ctl.sh_sel    = fsel[1:0];
    if (fsel[3]) ctl.alu_sel = {2'b10, fsel[1:0]};
    else         ctl.alu_sel = fsel;
  end
endmodule

// File: rtl/fn_alu.sv
module fn_alu #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [3:0]       sel,
  output logic [WIDTH-1:0] g,
  output logic             c,
  output logic             v
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] y;
  logic [WIDTH:0]   sum;
  logic [WIDTH-1:0] lg;

  always_comb begin
    unique case (sel[2:1])
      2'd0:    y = '0;
      2'd1:    y = b;
      2'd2:    y = ~b;
      default: y = '1;
    endcase
    sum = {1'b0, a} + {1'b0, y} + {{WIDTH{1'b0}}, sel[0]};
  end

  always_comb begin
    unique case (sel[1:0])
      2'd0:    lg = a & b;
      2'd1:    lg = a | b;
      2'd2:    lg = a ^ b;
      default: lg = ~a;
    endcase
  end

  always_comb begin
    if (sel[3]) begin
      g = lg;
      c = 1'b0;
      v = 1'b0;
    end else begin
      g = sum[WIDTH-1:0];
      c = sum[WIDTH];
      v = (a[MSB] == y[MSB]) && (sum[MSB] != a[MSB]);
    end
  end
endmodule

// File: rtl/fn_shift.sv
module fn_shift #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       sel,
  output logic [WIDTH-1:0] h
);
  localparam logic FILL_R = 1'b0;
  localparam logic FILL_L = 1'b0;

  logic [WIDTH-1:0] shr, shl;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == WIDTH - 1) begin : g_top
      assign shr[i] = FILL_R;
    end else begin : g_mid_r
      assign shr[i] = b[i+1];
    end
    if (i == 0) begin : g_bot
      assign shl[i] = FILL_L;
    end else begin : g_mid_l
      assign shl[i] = b[i-1];
    end
  end

  always_comb begin
    unique case (sel)
      2'd0:    h = b;
      2'd1:    h = shr;
      2'd2:    h = shl;
      default: h = '0;
    endcase
  end
endmodule

// File: rtl/fn_unit.sv
module fn_unit
  import fn_unit_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [3:0]       fsel,
  output logic [WIDTH-1:0] result,
  output logic             ovf,
  output logic             cout,
  output logic             neg,
  output logic             zero
);
  fn_ctl_t          ctl;
  logic [WIDTH-1:0] g_res, h_res;
  logic             g_c, g_v;

  fn_decode u_dec (.fsel(fsel), .ctl(ctl));

  fn_alu #(.WIDTH(WIDTH)) u_alu (
    .a(opnd_a), .b(opnd_b), .sel(ctl.alu_sel), .g(g_res), .c(g_c), .v(g_v)
  );

  fn_shift #(.WIDTH(WIDTH)) u_shf (
    .b(opnd_b), .sel(ctl.sh_sel), .h(h_res)
  );

  always_comb begin
    if (ctl.use_shift) begin
      result = h_res;
      cout   = 1'b0;
      ovf    = 1'b0;
    end else begin
      result = g_res;
      cout   = g_c;
      ovf    = g_v;
    end
    neg  = result[WIDTH-1];
    zero = ~|result;
  end
endmodule

// File: rtl/fn_unit_chk.sv
module fn_unit_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [3:0]       fsel,
  input logic [WIDTH-1:0] result,
  input logic             ovf,
  input logic             cout,
  input logic             neg,
  input logic             zero
);
  always_comb begin
    if (fsel == 4'b0000)
      a_r1_move_a: assert (result == opnd_a && !cout && !ovf);
    if (fsel == 4'b0111)
      a_r2_carry_on_pass: assert (result == opnd_a && cout);
    if (fsel == 4'b1100)
      a_r5_pass_b: assert (result == opnd_b);
    if (fsel[3])
      a_r8_no_carry_ovf: assert (!cout && !ovf);
    if (fsel == 4'b1111)
      a_r9_unused_zero: assert (result == '0 && zero && !neg);
    if (fsel == 4'b1101)
      a_r6_right_fill: assert (!neg);
  end
endmodule

bind fn_unit fn_unit_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/fn_unit_tb.sv
module fn_unit_tb;
  localparam int W = 16;

  typedef struct {
    logic [3:0]   fs;
    logic [W-1:0] f;
    logic         v, c, n, z;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [3:0]   fs = 4'd0;
  logic [W-1:0] f;
  logic         v, c, n, z;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  exp_t  q[$];

  always #10 clk = ~clk;  // 50 MHz

  fn_unit #(.WIDTH(W)) u_dut (
    .opnd_a(a), .opnd_b(b), .fsel(fs),
    .result(f), .ovf(v), .cout(c), .neg(n), .zero(z)
  );

  function automatic string res_tag(logic [3:0] code);
    if (code <= 4'd7)  return "R1";
    if (code <= 4'd11) return "R4";
    if (code == 4'd12) return "R5";
    if (code == 4'd13) return "R6";
    if (code == 4'd14) return "R7";
    return "R9";
  endfunction

  function automatic exp_t model(logic [3:0] code, logic [W-1:0] x, logic [W-1:0] y);
    exp_t e;
    logic [W-1:0] op2;
    logic         ci;
    logic [W:0]   s;
    e.fs = code; e.v = 1'b0; e.c = 1'b0; e.f = '0;
    op2 = '0; ci = 1'b0;
    case (code)
      4'd0:  begin op2 = '0;  ci = 1'b0; end
      4'd1:  begin op2 = '0;  ci = 1'b1; end
      4'd2:  begin op2 = y;   ci = 1'b0; end
      4'd3:  begin op2 = y;   ci = 1'b1; end
      4'd4:  begin op2 = ~y;  ci = 1'b0; end
      4'd5:  begin op2 = ~y;  ci = 1'b1; end
      4'd6:  begin op2 = '1;  ci = 1'b0; end
      4'd7:  begin op2 = '1;  ci = 1'b1; end
      default: ;
    endcase
    s = {1'b0, x} + {1'b0, op2} + (W+1)'(ci);
    case (code)
      4'd8:  e.f = x & y;
      4'd9:  e.f = x | y;
      4'd10: e.f = x ^ y;
      4'd11: e.f = ~x;
      4'd12: e.f = y;
      4'd13: e.f = y >> 1;
      4'd14: e.f = y << 1;
      4'd15: e.f = '0;
      default: begin
        e.f = s[W-1:0];
        e.c = s[W];
        e.v = (x[W-1] == op2[W-1]) && (s[W-1] != x[W-1]);
      end
    endcase
    e.n = e.f[W-1];
    e.z = (e.f == '0);
    return e;
  endfunction

  task automatic drive(logic [3:0] code, logic [W-1:0] x, logic [W-1:0] y);
    @(posedge clk);
    #1;
    a = x; b = y; fs = code;
    q.push_back(model(code, x, y));
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s fs=%b a=%h b=%h actual=%h expected=%h", tag, fs, a, b, act, exp);
    end
  endtask

  // Monitor: compares at the falling edge following each applied vector.
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(res_tag(e.fs), int'(f), int'(e.f));
      if (e.fs <= 4'd7) begin
        chk("R2 carry", int'(c), int'(e.c));
        chk("R3 overflow", int'(v), int'(e.v));
      end else begin
        chk("R8 carry", int'(c), 0);
        chk("R8 overflow", int'(v), 0);
      end
      chk("R10 zero", int'(z), int'(e.z));
      chk("R11 negative", int'(n), int'(e.n));
    end
  end

  initial begin
    logic [W-1:0] corners [8];
    corners[0] = '0;
    corners[1] = '1;
    corners[2] = {1'b1, {(W-1){1'b0}}};
    corners[3] = {1'b0, {(W-1){1'b1}}};
    corners[4] = {(W/2){2'b10}};
    corners[5] = {(W/2){2'b01}};
    corners[6] = W'(1);
    corners[7] = W'(16'h00FF);
    repeat (3) @(posedge clk);
    #1;
    // Idle state after reset: all-zero inputs, code 0 -> result 0, zero set.
    checks++;
    if (f !== '0 || z !== 1'b1) begin
      errors++;
      $display("FAIL R10 idle actual=%h/%b expected=0/1", f, z);
    end
    rst_n = 1'b1;
    for (int k = 0; k < 16; k++) begin
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          drive(4'(k), corners[i], corners[j]);
      for (int r = 0; r < 40; r++)
        drive(4'(k), W'($urandom), W'($urandom));
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule